// File: doc/BRIEF.md
# Two-Master Card Bus Arbiter

This block shares a local card bus between two masters: the host CPU port and an on-card DMA engine. A three-state machine decides who owns the bus: the CPU, the DMA engine, or nobody. Each grant covers exactly one unit of work. For the CPU that is one instruction or access; for the DMA engine it is one byte transfer. There is no locked or burst tenure, so the two masters can swap the bus after every transfer.

The request and done lines arrive from other clock domains. Each one passes through a two-flop synchronizer before the state machine uses it. The grant outputs come straight from flops. The arbiter never takes the bus away in the middle of a transfer. The owner keeps it until its done line is seen, unless both requests have gone away.

All latencies below count rising edges of `clk`, starting from the edge after an input changes. Two edges go to synchronization and one to the grant register, so a grant follows its cause on the third edge.

Top module: `card_bus_arbiter`

## Requirements
- R1: While `rst` is high at a rising edge, both grants are low after that edge, and the arbiter is idle.
- R2: If neither request is seen high, both grants are low three edges later, whoever owned the bus before.
- R3: From idle, one request is granted on the third edge after it is raised, and not before.
- R4: If both requests are seen together while idle, `cpu_gnt` goes high first. The DMA engine gets the bus on the third edge after the CPU's done pulse.
- R5: While the CPU owns the bus and `dma_req` is pending, `cpu_gnt` stays high until a `cpu_done` pulse. Three edges after that pulse, `dma_gnt` is high and `cpu_gnt` is low.
- R6: While the DMA engine owns the bus and `cpu_req` is pending, `dma_gnt` stays high until a `dma_done` pulse. Three edges after that pulse, `cpu_gnt` is high and `dma_gnt` is low.
- R7: When the owner's done pulse comes with no other request pending and the owner's request still high, the owner keeps its grant for another transfer.
- R8: `cpu_gnt` and `dma_gnt` are never high at the same time, and both are driven from flops.
- R9: A done pulse from the master that does not own the bus has no effect on the grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock (4 MHz in the target system) |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Host CPU bus request, asynchronous |
| cpu_done | input | 1 | Host CPU instruction/access complete, asynchronous |
| dma_req | input | 1 | DMA bus request, asynchronous |
| dma_done | input | 1 | DMA byte transfer complete, asynchronous |
| cpu_gnt | output | 1 | Bus granted to the host CPU, registered |
| dma_gnt | output | 1 | Bus granted to the DMA engine, registered |

## Verification
The assertions are written on the synchronized request and done values. They therefore take nothing for granted about when the raw inputs change. A done pulse from a master that does not own the bus is legal and must be ignored.

The random stimulus toggles requests freely and fires done pulses on either line at any time, owner or not. Done pulses are held for at least one full clock cycle, so the synchronizers never miss them. A bench model applies the same three-edge latency to predict each grant.

// File: rtl/cbarb_pkg.sv
package cbarb_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_DMA  = 2'd2
  } owner_t;

  // bit positions in the synchronized input vector
  localparam int IDX_CPU_REQ  = 0;
  localparam int IDX_CPU_DONE = 1;
  localparam int IDX_DMA_REQ  = 2;
  localparam int IDX_DMA_DONE = 3;
  localparam int NUM_IN       = 4;
endpackage

// File: rtl/cbarb_sync.sv
module cbarb_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cbarb_fsm.sv
module cbarb_fsm
  import cbarb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cpu_req_s,
  input  logic cpu_done_s,
  input  logic dma_req_s,
  input  logic dma_done_s,
  output logic cpu_gnt,
  output logic dma_gnt
);
  owner_t state_q, state_nxt;

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      OWN_IDLE: begin
        if (cpu_req_s)      state_nxt = OWN_CPU;
        else if (dma_req_s) state_nxt = OWN_DMA;
      end
      OWN_CPU: begin
        if (!cpu_req_s && !dma_req_s) state_nxt = OWN_IDLE;
        else if (cpu_done_s) begin
          if (dma_req_s)      state_nxt = OWN_DMA;
          else if (cpu_req_s) state_nxt = OWN_CPU;
          else                state_nxt = OWN_IDLE;
        end
      end
      OWN_DMA: begin
        if (!cpu_req_s && !dma_req_s) state_nxt = OWN_IDLE;
        else if (dma_done_s) begin
          if (cpu_req_s)      state_nxt = OWN_CPU;
          else if (dma_req_s) state_nxt = OWN_DMA;
          else                state_nxt = OWN_IDLE;
        end
      end
      default: state_nxt = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= OWN_IDLE;
      cpu_gnt <= 1'b0;
      dma_gnt <= 1'b0;
    end else begin
      state_q <= state_nxt;
      cpu_gnt <= (state_nxt == OWN_CPU);
      dma_gnt <= (state_nxt == OWN_DMA);
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!cpu_gnt && !dma_gnt));

  p_no_req_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!cpu_req_s && !dma_req_s) |=> (!cpu_gnt && !dma_gnt));

  p_idle_grant_r3: assert property (@(posedge clk) disable iff (rst)
    (!cpu_gnt && !dma_gnt && (cpu_req_s || dma_req_s)) |=> (cpu_gnt || dma_gnt));

  p_cpu_first_r4: assert property (@(posedge clk) disable iff (rst)
    (!cpu_gnt && !dma_gnt && cpu_req_s) |=> cpu_gnt);

  p_cpu_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_gnt && !cpu_done_s && (cpu_req_s || dma_req_s)) |=> cpu_gnt);

  p_dma_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (dma_gnt && !dma_done_s && (cpu_req_s || dma_req_s)) |=> dma_gnt);

  p_handover_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_gnt && cpu_done_s && dma_req_s) |=> (dma_gnt && !cpu_gnt));

  p_handover_r6: assert property (@(posedge clk) disable iff (rst)
    (dma_gnt && dma_done_s && cpu_req_s) |=> (cpu_gnt && !dma_gnt));

  p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(cpu_gnt && dma_gnt));
endmodule

// File: rtl/card_bus_arbiter.sv
module card_bus_arbiter
  import cbarb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cpu_req,
  input  logic cpu_done,
  input  logic dma_req,
  input  logic dma_done,
  output logic cpu_gnt,
  output logic dma_gnt
);
  logic [NUM_IN-1:0] raw_in, synced;

  always_comb begin
    raw_in               = '0;
    raw_in[IDX_CPU_REQ]  = cpu_req;
    raw_in[IDX_CPU_DONE] = cpu_done;
    raw_in[IDX_DMA_REQ]  = dma_req;
    raw_in[IDX_DMA_DONE] = dma_done;
  end

  cbarb_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (raw_in),
    .q_sync  (synced)
  );

  cbarb_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cpu_req_s  (synced[IDX_CPU_REQ]),
    .cpu_done_s (synced[IDX_CPU_DONE]),
    .dma_req_s  (synced[IDX_DMA_REQ]),
    .dma_done_s (synced[IDX_DMA_DONE]),
    .cpu_gnt    (cpu_gnt),
    .dma_gnt    (dma_gnt)
  );
endmodule

// File: tb/card_bus_arbiter_bench.sv
module card_bus_arbiter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_done = 1'b0, dma_req = 1'b0, dma_done = 1'b0;
  logic cpu_gnt, dma_gnt;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  card_bus_arbiter u_card_bus_arbiter (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_done(cpu_done),
    .dma_req(dma_req), .dma_done(dma_done), .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt)
  );

  // Reference owner: 0 idle, 1 cpu, 2 dma
  function automatic logic [1:0] ref_next(logic [1:0] st, logic cr, logic cd,
                                          logic dr, logic dd);
    case (st)
      2'd1: begin
        if (!cr && !dr) return 2'd0;
        if (cd) return dr ? 2'd2 : (cr ? 2'd1 : 2'd0);
        return 2'd1;
      end
      2'd2: begin
        if (!cr && !dr) return 2'd0;
        if (dd) return cr ? 2'd1 : (dr ? 2'd2 : 2'd0);
        return 2'd2;
      end
      default: return cr ? 2'd1 : (dr ? 2'd2 : 2'd0);
    endcase
  endfunction

  logic [3:0] m_s1 = '0, m_s2 = '0;
  logic [1:0] m_own = 2'd0;
  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_own <= 2'd0;
    end else begin
      m_s1  <= {dma_done, dma_req, cpu_done, cpu_req};
      m_s2  <= m_s1;
      m_own <= ref_next(m_own, m_s2[0], m_s2[1], m_s2[2], m_s2[3]);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_gnt(logic ec, logic ed, string tag);
    checks++;
    if (cpu_gnt !== ec || dma_gnt !== ed) begin
      fails++;
      $display("FAIL %s: gnt cpu/dma actual %b%b expected %b%b", tag,
               cpu_gnt, dma_gnt, ec, ed);
    end
  endtask

  task automatic pulse_cpu_done();
    cpu_done = 1'b1; step(1); cpu_done = 1'b0;
  endtask

  task automatic pulse_dma_done();
    dma_done = 1'b1; step(1); dma_done = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    step(3);
    expect_gnt(0, 0, "R1 reset");
    rst = 1'b0;
    step(4);
    expect_gnt(0, 0, "R2 no requests");

    cpu_req = 1'b1;
    step(2); expect_gnt(0, 0, "R3 latency not yet");
    step(1); expect_gnt(1, 0, "R3 idle grant cpu");

    pulse_cpu_done();
    step(4); expect_gnt(1, 0, "R7 owner keeps bus");

    dma_req = 1'b1;
    step(6); expect_gnt(1, 0, "R5 cpu holds while dma waits");
    cpu_req = 1'b0;
    pulse_cpu_done();
    step(2); expect_gnt(0, 1, "R5 handover to dma");

    pulse_cpu_done();
    step(4); expect_gnt(0, 1, "R9 non-owner done ignored");

    cpu_req = 1'b1;
    step(5); expect_gnt(0, 1, "R6 dma holds while cpu waits");
    pulse_dma_done();
    step(2); expect_gnt(1, 0, "R6 handover to cpu");

    pulse_dma_done();
    step(4); expect_gnt(1, 0, "R9 dma done ignored under cpu");

    pulse_cpu_done();
    step(2); expect_gnt(0, 1, "R5 alternation back to dma");

    cpu_req = 1'b0; dma_req = 1'b0;
    step(3); expect_gnt(0, 0, "R2 both dropped");

    cpu_req = 1'b1; dma_req = 1'b1;
    step(3); expect_gnt(1, 0, "R4 cpu wins tie");
    pulse_cpu_done();
    step(2); expect_gnt(0, 1, "R4 dma served next");
    cpu_req = 1'b0; dma_req = 1'b0;
    step(4); expect_gnt(0, 0, "R2 idle after tie test");

    for (int k = 0; k < 3000; k++) begin
      checks++;
      if (cpu_gnt !== (m_own == 2'd1) || dma_gnt !== (m_own == 2'd2)) begin
        fails++;
        $display("FAIL R8 random cycle %0d: gnt actual %b%b expected %b%b", k,
                 cpu_gnt, dma_gnt, m_own == 2'd1, m_own == 2'd2);
      end
      checks++;
      if (cpu_gnt && dma_gnt) begin
        fails++;
        $display("FAIL R8 exclusive: actual 11 expected not 11");
      end
      if ($urandom_range(3) == 0) cpu_req = ~cpu_req;
      if ($urandom_range(3) == 0) dma_req = ~dma_req;
      cpu_done = ($urandom_range(2) == 0);
      dma_done = ($urandom_range(2) == 0);
      step(1);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule